// File: doc/BRIEF.md
# FIFO Trigger-Level Interrupt Generator

This block watches the fill counts of a receive FIFO and a transmit FIFO and produces two interrupt requests. The receive request tells software that enough characters are waiting. The transmit request tells software that the transmit FIFO has drained and can take more data. The thresholds come from a 2-bit code per direction, written through a FIFO control write port. Each code is resolved against one of four level tables.

Only one table is active at any time, and both directions use it. There are two independent table-select write ports, one on the receive side and one on the transmit side. The table written most recently through either port is the one in force.

The transmit request fires when the count falls from at or above its level to below it. If a refill never reached the level, the request instead fires when the FIFO is empty. The block contains no FIFO storage, no serial logic and no interrupt prioritization.

Top module: `fifo_trig_irq`

## Requirements
- R1: While `rst_n` is low, both requests are 0, both codes are 0 and table 0 is active. The defaults therefore give a level of 1 for each direction.
- R2: `rx_irq` is registered. One clock after the edge that samples `rx_count`, it is 1 if that count is greater than or equal to the active receive level, and 0 otherwise.
- R3: The receive code is taken from `ctl_wdata[7:6]` on every `ctl_we`. Codes 0..3 map to these levels: table 0 gives 1, 4, 8, 14; table 1 gives 8, 16, 24, 28; table 2 gives 8, 16, 56, 60; table 3 gives 8, 16, 32, 56.
- R4: The transmit code is taken from `ctl_wdata[5:4]` on a `ctl_we` only when `enh_en` is 1. When `enh_en` is 0, the transmit code keeps its previous value.
- R5: A write on either `rx_tbl_we` or `tx_tbl_we` replaces the shared table for both directions. When both ports write in the same cycle, the transmit-side value is kept.
- R6: A transmit count at or above the transmit level clears `tx_irq` on the next clock and marks the FIFO as filled. A later count below the level raises `tx_irq` on the next clock and removes the mark.
- R7: A transmit count of 0 raises `tx_irq` on the next clock, including when the last refill never reached the level.
- R8: A transmit count that is nonzero and below the level, with no mark set, leaves `tx_irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_count | input | 9 | Receive FIFO occupancy |
| tx_count | input | 9 | Transmit FIFO occupancy |
| enh_en | input | 1 | Enables writes to the transmit code |
| ctl_we | input | 1 | FIFO control write strobe |
| ctl_wdata | input | 8 | FIFO control write data |
| rx_tbl_we | input | 1 | Receive-side table-select write strobe |
| rx_tbl_sel | input | 2 | Receive-side table number |
| tx_tbl_we | input | 1 | Transmit-side table-select write strobe |
| tx_tbl_sel | input | 2 | Transmit-side table number |
| rx_irq | output | 1 | Receive-ready request |
| tx_irq | output | 1 | Transmit-ready request |

## Verification
Two things can land in the same cycle: a table write from the receive side and one from the transmit side. The bench writes table 3 through the receive port and table 2 through the transmit port on one clock. It then judges which table won by reading the receive request at a count of 57, which sits between the code-3 levels of those two tables (60 and 56). The ordered case, with writes in successive cycles, is run as well. That confirms the later write replaces the earlier one.

// File: rtl/fifo_trig_irq.sv
module fifo_trig_irq #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          enh_en,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          rx_tbl_we,
  input  logic [1:0]    rx_tbl_sel,
  input  logic          tx_tbl_we,
  input  logic [1:0]    tx_tbl_sel,
  output logic          rx_irq,
  output logic          tx_irq
);

  logic [1:0] rx_code, tx_code, tbl;
  logic       filled;

  function automatic logic [CW-1:0] level(input logic [1:0] t, input logic [1:0] c);
    logic [5:0] v;
    case ({t, c})
      4'h0: v = 6'd1;   4'h1: v = 6'd4;   4'h2: v = 6'd8;   4'h3: v = 6'd14;
      4'h4: v = 6'd8;   4'h5: v = 6'd16;  4'h6: v = 6'd24;  4'h7: v = 6'd28;
      4'h8: v = 6'd8;   4'h9: v = 6'd16;  4'hA: v = 6'd56;  4'hB: v = 6'd60;
      4'hC: v = 6'd8;   4'hD: v = 6'd16;  4'hE: v = 6'd32;  default: v = 6'd56;
    endcase
    return CW'(v);
  endfunction

  wire [CW-1:0] rx_lvl = level(tbl, rx_code);
  wire [CW-1:0] tx_lvl = level(tbl, tx_code);
  wire          tx_at  = tx_count >= tx_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_code <= '0;
      tx_code <= '0;
      tbl     <= '0;
    end else begin
      if (ctl_we) rx_code <= ctl_wdata[7:6];
      if (ctl_we && enh_en) tx_code <= ctl_wdata[5:4];
      if (tx_tbl_we)      tbl <= tx_tbl_sel;
      else if (rx_tbl_we) tbl <= rx_tbl_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
      filled <= 1'b0;
    end else begin
      rx_irq <= rx_count >= rx_lvl;
      if (tx_at) begin
        tx_irq <= 1'b0;
        filled <= 1'b1;
      end else if (filled) begin
        tx_irq <= 1'b1;
        filled <= 1'b0;
      end else if (tx_count == '0) begin
        tx_irq <= 1'b1;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> (!rx_irq && !tx_irq));

  a_r2_rx_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rx_count) == '0) |-> !rx_irq);

  a_r2_rx_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rx_count) >= CW'(60)) |-> rx_irq);

  a_r4_tx_code_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !enh_en) |=> $stable(tx_code));

  a_r5_tx_side_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tbl_we && tx_tbl_we) |=> tbl == $past(tx_tbl_sel));

  a_r6_tx_full_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_count) >= CW'(60)) |-> !tx_irq);

  a_r7_tx_empty_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tx_count) == '0) |-> tx_irq);

endmodule

// File: tb/fifo_trig_irq_tb.sv
module fifo_trig_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {rx_count, tx_count, exp_rx, exp_tx}; table 1, rx level 24, tx level 16
  localparam logic [19:0] VEC [NV] = '{
    {9'd0,   9'd0,  1'b0, 1'b1},
    {9'd23,  9'd5,  1'b0, 1'b1},
    {9'd24,  9'd16, 1'b1, 1'b0},
    {9'd30,  9'd20, 1'b1, 1'b0},
    {9'd25,  9'd15, 1'b1, 1'b1},
    {9'd10,  9'd10, 1'b0, 1'b1},
    {9'd0,   9'd3,  1'b0, 1'b1},
    {9'd100, 9'd40, 1'b1, 1'b0},
    {9'd24,  9'd0,  1'b1, 1'b1},
    {9'd0,   9'd12, 1'b0, 1'b1},
    {9'd0,   9'd0,  1'b0, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic [8:0] rx_count = 0, tx_count = 0;
  logic enh_en = 0, ctl_we = 0, rx_tbl_we = 0, tx_tbl_we = 0;
  logic [7:0] ctl_wdata = 0;
  logic [1:0] rx_tbl_sel = 0, tx_tbl_sel = 0;
  logic rx_irq, tx_irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_trig_irq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .enh_en(enh_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .rx_tbl_we(rx_tbl_we), .rx_tbl_sel(rx_tbl_sel),
    .tx_tbl_we(tx_tbl_we), .tx_tbl_sel(tx_tbl_sel),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [8:0] rc, input logic [8:0] tc);
    rx_count = rc; tx_count = tc;
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] d);
    ctl_wdata = d; ctl_we = 1;
    @(negedge clk);
    ctl_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rx reset", rx_irq, 1'b0);
    check("R1 tx reset", tx_irq, 1'b0);
    rst_n = 1;
    @(negedge clk);

    enh_en = 1;
    ctl_write(8'h90);
    rx_tbl_sel = 2'd1; rx_tbl_we = 1;
    @(negedge clk);
    rx_tbl_we = 0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19:11], VEC[i][10:2]);
      check($sformatf("R2 vec %0d rx", i), rx_irq, VEC[i][1]);
      check($sformatf("R6/R7/R8 vec %0d tx", i), tx_irq, VEC[i][0]);
    end

    rst_n = 0; rx_count = 0; tx_count = 0; enh_en = 0;
    @(negedge clk);
    rst_n = 1;
    step(9'd0, 9'd0);
    check("R7 empty after reset", tx_irq, 1'b1);
    ctl_write(8'h30);
    step(9'd0, 9'd1);
    check("R4 tx code held with enh_en=0", tx_irq, 1'b0);
    enh_en = 1;
    ctl_write(8'h30);
    step(9'd0, 9'd1);
    check("R4 tx code taken with enh_en=1", tx_irq, 1'b1);

    ctl_write(8'h80);
    step(9'd7, 9'd0);
    check("R3 table0 code2 below", rx_irq, 1'b0);
    step(9'd8, 9'd0);
    check("R3 table0 code2 at level", rx_irq, 1'b1);

    ctl_write(8'hC0);
    tx_tbl_sel = 2'd2; tx_tbl_we = 1;
    @(negedge clk);
    tx_tbl_we = 0;
    rx_tbl_sel = 2'd3; rx_tbl_we = 1;
    @(negedge clk);
    rx_tbl_we = 0;
    step(9'd57, 9'd0);
    check("R5 later rx-side write wins", rx_irq, 1'b1);

    rx_tbl_sel = 2'd3; rx_tbl_we = 1;
    tx_tbl_sel = 2'd2; tx_tbl_we = 1;
    @(negedge clk);
    rx_tbl_we = 0; tx_tbl_we = 0;
    step(9'd57, 9'd0);
    check("R5 same-cycle tx-side wins", rx_irq, 1'b0);
    step(9'd60, 9'd0);
    check("R3 table2 code3 at level", rx_irq, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule